// File: doc/BRIEF.md
# Sealed Interrupt Context Save and Restore Unit

This block sits beside the sequencer of a core whose instructions are chained by keys: every instruction carries a key that decrypts the register image and a key that re-encrypts it. When an interrupt or exception is taken at an instruction boundary, the unit captures four things:

- the pointer of the instruction that would have run next;
- the register image, still encrypted;
- that instruction's decrypt key;
- that instruction's re-encrypt key.

It authenticates this context with a keyed tag under the master key, encrypts it, and pushes the sealed record onto a save area with one slot per nesting level. It then derives the handler's entry key as a keyed tag of the handler number. The handler starts on that key and does not continue the interrupted chain.

On an interrupt-return the unit pops the newest record and decrypts it. It recomputes the tag and compares it with the stored one. If they match, it hands back the pointer, the register image and both keys. A mismatch, a push onto a full save area, or a pop from an empty one moves the unit into a halt state that only reset clears.

The cipher and tag engines live outside the block and are reached through one request/acknowledge port. A request names an operation and carries a data word. The unit also pulses a flush request when it takes an interrupt and when it completes a resume.

Top module: `sic_ctx_unit`

## Requirements
- R1: After reset, `busy`, `halt`, `cr_req`, `irq_take`, `flush`, `hnd_valid` and `res_valid` are all low.
- R2: An interrupt is taken only in a cycle with `at_boundary` high, `irq_req` high and the unit idle. The taking is shown by a one-cycle `irq_take` pulse, together with a one-cycle `flush` pulse, in the following cycle.
- R3: A save issues exactly two crypto requests in this order: first a tag request (`cr_op`=2), then an encrypt request (`cr_op`=0). Both carry the context word {pointer, registers, decrypt key, re-encrypt key}, pointer in the top bits and re-encrypt key in the bottom bits. Each request holds its operation and data steady until `cr_ack`.
- R4: After the save, a tag request (`cr_op`=2) is made on the handler number, zero-extended into the data word. The low key-width bits of its result appear on `hnd_key` during a one-cycle `hnd_valid` pulse, with the unit idle.
- R5: An interrupt-return taken at a boundary issues a decrypt request (`cr_op`=1) on the stored ciphertext, then a tag request on the decrypted word. If the tag matches, `res_valid` and `flush` pulse for one cycle. The pulse carries the saved pointer, registers, decrypt key (`res_kdec`) and re-encrypt key (`res_kchain`).
- R6: If the recomputed tag differs from the stored one, `res_valid` never pulses and `halt` rises.
- R7: An interrupt that arrives while a save or restore is in progress is not taken until that operation completes. It is then taken at the next boundary.
- R8: Records are restored last-in first-out.
- R9: Taking an interrupt with all `DEPTH` levels in use raises `halt` without a save and without an `irq_take` pulse.
- R10: An interrupt-return with an empty save area raises `halt`.
- R11: When an interrupt and an interrupt-return are both requested in the same idle boundary cycle, the interrupt is taken.
- R12: Once halted, the unit stays halted until reset, issues no crypto request and produces no resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Core is between two instructions |
| irq_req | input | 1 | Interrupt or exception request (level) |
| irq_id | input | IDW | Handler number of the request |
| ctx_ip | input | IPW | Pointer of the instruction that would run next |
| ctx_regs | input | NREG*RW | Encrypted register image |
| ctx_kprev | input | KW | Decrypt key of the next instruction |
| ctx_knext | input | KW | Re-encrypt key of the next instruction |
| iret_req | input | 1 | Interrupt-return request (level) |
| cr_req | output | 1 | Crypto request valid |
| cr_op | output | 2 | Crypto operation: 0 encrypt, 1 decrypt, 2 tag |
| cr_din | output | BW | Crypto data word |
| cr_ack | input | 1 | Crypto result valid (one cycle) |
| cr_dout | input | BW | Crypto result; a tag is in the low KW bits |
| busy | output | 1 | Save or restore in progress |
| halt | output | 1 | Fatal stop (sticky) |
| irq_take | output | 1 | Interrupt taken (pulse) |
| flush | output | 1 | Pipeline flush request (pulse) |
| hnd_valid | output | 1 | Handler entry key valid (pulse) |
| hnd_key | output | KW | Handler entry key |
| res_valid | output | 1 | Resume data valid (pulse) |
| res_ip | output | IPW | Restored pointer |
| res_regs | output | NREG*RW | Restored encrypted register image |
| res_kdec | output | KW | Restored decrypt key for the registers |
| res_kchain | output | KW | Restored key that becomes the next previous key |

## Verification
The hardest case to reach from the ports is a tag mismatch on restore. The stored record never leaves the block, so the unit's own writes cannot corrupt it. The bench therefore reaches it through its stand-in crypto engine: for one chosen decrypt it flips a bit of the returned word, and this must end in halt with no resume. Nested requests that arrive during a save or a restore are produced by holding a second request high while the first is still busy. Bit patterns are swept across every handler number so that each save and restore round trip covers distinct contexts.

// File: rtl/sic_pkg.sv
package sic_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEAL_MAC,
        ST_SEAL_ENC,
        ST_HKEY,
        ST_OPEN_DEC,
        ST_OPEN_MAC,
        ST_HALT
    } sic_state_e;

    localparam logic [1:0] CR_ENC = 2'd0;
    localparam logic [1:0] CR_DEC = 2'd1;
    localparam logic [1:0] CR_MAC = 2'd2;
endpackage

// File: rtl/sic_stack.sv
module sic_stack #(
    parameter int EW    = 48,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [EW-1:0]                push_data,
    output logic [EW-1:0]                top_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [LW-1:0]            lvl;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [LW-1:0] lvl_m1;

    assign lvl_m1   = stk_q.lvl - LW'(1);
    assign top_data = stk_q.mem[lvl_m1[AW-1:0]];
    assign level    = stk_q.lvl;
    assign full     = (stk_q.lvl == LW'(DEPTH));
    assign empty    = (stk_q.lvl == '0);

    always_comb begin
        stk_d = stk_q;
        if (push && !full) begin
            stk_d.mem[stk_q.lvl[AW-1:0]] = push_data;
            stk_d.lvl = stk_q.lvl + LW'(1);
        end else if (pop && !empty) begin
            stk_d.lvl = lvl_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.lvl <= LW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(stk_q.lvl));
endmodule

// File: rtl/sic_req_mux.sv
module sic_req_mux
    import sic_pkg::*;
#(
    parameter int BW  = 40,
    parameter int IDW = 4
) (
    input  sic_state_e       st,
    input  logic [BW-1:0]    blob,
    input  logic [BW-1:0]    ct,
    input  logic [IDW-1:0]   hid,
    output logic             cr_req,
    output logic [1:0]       cr_op,
    output logic [BW-1:0]    cr_din
);
    always_comb begin
        cr_req = 1'b1;
        cr_op  = CR_MAC;
        cr_din = blob;
        case (st)
            ST_SEAL_MAC: begin cr_op = CR_MAC; cr_din = blob; end
            ST_SEAL_ENC: begin cr_op = CR_ENC; cr_din = blob; end
            ST_HKEY:     begin cr_op = CR_MAC; cr_din = {{(BW-IDW){1'b0}}, hid}; end
            ST_OPEN_DEC: begin cr_op = CR_DEC; cr_din = ct; end
            ST_OPEN_MAC: begin cr_op = CR_MAC; cr_din = blob; end
            default:     begin cr_req = 1'b0; cr_din = '0; end
        endcase
    end
endmodule

// File: rtl/sic_ctx_unit.sv
module sic_ctx_unit
    import sic_pkg::*;
#(
    parameter int IPW   = 8,
    parameter int NREG  = 2,
    parameter int RW    = 8,
    parameter int KW    = 8,
    parameter int IDW   = 4,
    parameter int DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  at_boundary,
    input  logic                  irq_req,
    input  logic [IDW-1:0]        irq_id,
    input  logic [IPW-1:0]        ctx_ip,
    input  logic [NREG*RW-1:0]    ctx_regs,
    input  logic [KW-1:0]         ctx_kprev,
    input  logic [KW-1:0]         ctx_knext,
    input  logic                  iret_req,
    output logic                  cr_req,
    output logic [1:0]            cr_op,
    output logic [IPW+NREG*RW+2*KW-1:0] cr_din,
    input  logic                  cr_ack,
    input  logic [IPW+NREG*RW+2*KW-1:0] cr_dout,
    output logic                  busy,
    output logic                  halt,
    output logic                  irq_take,
    output logic                  flush,
    output logic                  hnd_valid,
    output logic [KW-1:0]         hnd_key,
    output logic                  res_valid,
    output logic [IPW-1:0]        res_ip,
    output logic [NREG*RW-1:0]    res_regs,
    output logic [KW-1:0]         res_kdec,
    output logic [KW-1:0]         res_kchain
);
    localparam int RIW = NREG * RW;
    localparam int BW  = IPW + RIW + 2 * KW;
    localparam int EW  = BW + KW;
    localparam int LW  = $clog2(DEPTH + 1);

    typedef struct packed {
        sic_state_e      st;
        logic [BW-1:0]   blob;
        logic [BW-1:0]   ct;
        logic [KW-1:0]   tag;
        logic [IDW-1:0]  hid;
        logic            take;
        logic            flush;
        logic            hvalid;
        logic [KW-1:0]   hkey;
        logic            rvalid;
    } ctx_t;

    ctx_t cur_q, nxt_d;

    logic          push, pop;
    logic [EW-1:0] push_data, top_data;
    logic [LW-1:0] level;
    logic          full, empty;

    sic_stack #(.EW(EW), .DEPTH(DEPTH)) i_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(push_data), .top_data(top_data), .level(level),
        .full(full), .empty(empty)
    );

    sic_req_mux #(.BW(BW), .IDW(IDW)) i_req (
        .st(cur_q.st), .blob(cur_q.blob), .ct(cur_q.ct), .hid(cur_q.hid),
        .cr_req(cr_req), .cr_op(cr_op), .cr_din(cr_din)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.take   = 1'b0;
        nxt_d.flush  = 1'b0;
        nxt_d.hvalid = 1'b0;
        nxt_d.rvalid = 1'b0;
        push         = 1'b0;
        pop          = 1'b0;
        push_data    = {cr_dout, cur_q.tag};
        case (cur_q.st)
            ST_IDLE: begin
                if (at_boundary && irq_req) begin
                    if (full) begin
                        nxt_d.st = ST_HALT;
                    end else begin
                        nxt_d.st    = ST_SEAL_MAC;
                        nxt_d.blob  = {ctx_ip, ctx_regs, ctx_kprev, ctx_knext};
                        nxt_d.hid   = irq_id;
                        nxt_d.take  = 1'b1;
                        nxt_d.flush = 1'b1;
                    end
                end else if (at_boundary && iret_req) begin
                    if (empty) begin
                        nxt_d.st = ST_HALT;
                    end else begin
                        nxt_d.st  = ST_OPEN_DEC;
                        nxt_d.ct  = top_data[EW-1:KW];
                        nxt_d.tag = top_data[KW-1:0];
                    end
                end
            end
            ST_SEAL_MAC: if (cr_ack) begin
                nxt_d.tag = cr_dout[KW-1:0];
                nxt_d.st  = ST_SEAL_ENC;
            end
            ST_SEAL_ENC: if (cr_ack) begin
                push     = 1'b1;
                nxt_d.st = ST_HKEY;
            end
            ST_HKEY: if (cr_ack) begin
                nxt_d.hkey   = cr_dout[KW-1:0];
                nxt_d.hvalid = 1'b1;
                nxt_d.st     = ST_IDLE;
            end
            ST_OPEN_DEC: if (cr_ack) begin
                nxt_d.blob = cr_dout;
                nxt_d.st   = ST_OPEN_MAC;
            end
            ST_OPEN_MAC: if (cr_ack) begin
                if (cr_dout[KW-1:0] == cur_q.tag) begin
                    pop          = 1'b1;
                    nxt_d.rvalid = 1'b1;
                    nxt_d.flush  = 1'b1;
                    nxt_d.st     = ST_IDLE;
                end else begin
                    nxt_d.st = ST_HALT;
                end
            end
            default: nxt_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy       = (cur_q.st != ST_IDLE) && (cur_q.st != ST_HALT);
    assign halt       = (cur_q.st == ST_HALT);
    assign irq_take   = cur_q.take;
    assign flush      = cur_q.flush;
    assign hnd_valid  = cur_q.hvalid;
    assign hnd_key    = cur_q.hkey;
    assign res_valid  = cur_q.rvalid;
    assign res_ip     = cur_q.blob[BW-1 -: IPW];
    assign res_regs   = cur_q.blob[2*KW +: RIW];
    assign res_kdec   = cur_q.blob[KW +: KW];
    assign res_kchain = cur_q.blob[KW-1:0];

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_req && !cr_ack) |=> (cr_req && $stable(cr_op) && $stable(cr_din)));

    // R2
    take_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(at_boundary) && $past(irq_req) && flush));

    // R6
    res_not_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!halt && flush));

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && !cr_req && !res_valid));

    // R4
    hnd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |-> !busy);
endmodule

// File: tb/test_sic_ctx_unit.sv
module test_sic_ctx_unit;
    localparam int BW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic at_boundary = 1'b0, irq_req = 1'b0, iret_req = 1'b0;
    logic [3:0]  irq_id = '0;
    logic [7:0]  ctx_ip = '0, ctx_kprev = '0, ctx_knext = '0;
    logic [15:0] ctx_regs = '0;
    logic        cr_req, cr_ack = 1'b0;
    logic [1:0]  cr_op;
    logic [BW-1:0] cr_din, cr_dout = '0;
    logic busy, halt, irq_take, flush, hnd_valid, res_valid;
    logic [7:0]  hnd_key, res_ip, res_kdec, res_kchain;
    logic [15:0] res_regs;

    always #2.5 clk = ~clk;

    sic_ctx_unit i_sic_ctx_unit (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
        .irq_id(irq_id), .ctx_ip(ctx_ip), .ctx_regs(ctx_regs), .ctx_kprev(ctx_kprev),
        .ctx_knext(ctx_knext), .iret_req(iret_req), .cr_req(cr_req), .cr_op(cr_op),
        .cr_din(cr_din), .cr_ack(cr_ack), .cr_dout(cr_dout), .busy(busy), .halt(halt),
        .irq_take(irq_take), .flush(flush), .hnd_valid(hnd_valid), .hnd_key(hnd_key),
        .res_valid(res_valid), .res_ip(res_ip), .res_regs(res_regs),
        .res_kdec(res_kdec), .res_kchain(res_kchain)
    );

    function automatic logic [BW-1:0] f_enc(input logic [BW-1:0] x);
        return x ^ 40'hA53C960F5A;
    endfunction

    function automatic logic [7:0] f_mac(input logic [BW-1:0] x);
        logic [7:0] r = 8'h5B;
        for (int i = 0; i < 5; i++) r = {r[6:0], r[7]} ^ x[i*8 +: 8];
        return r;
    endfunction

    // stand-in crypto engine, fixed latency, with a one-shot decrypt corruption
    int        log_n = 0;
    logic [1:0]    log_op [256];
    logic [BW-1:0] log_din [256];
    int  lat_cnt = 0;
    bit  corrupt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cr_ack  <= 1'b0;
            lat_cnt <= 0;
        end else if (cr_ack) begin
            cr_ack <= 1'b0;
        end else if (cr_req) begin
            if (lat_cnt == 2) begin
                lat_cnt <= 0;
                cr_ack  <= 1'b1;
                case (cr_op)
                    2'd0: cr_dout <= f_enc(cr_din);
                    2'd1: cr_dout <= f_enc(cr_din) ^ (corrupt ? 40'h1 : 40'h0);
                    default: cr_dout <= {32'h0, f_mac(cr_din)};
                endcase
                if (log_n < 256) begin
                    log_op[log_n]  <= cr_op;
                    log_din[log_n] <= cr_din;
                end
                log_n <= log_n + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_flag(input int which, input int maxc, output bit seen);
        seen = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            @(negedge clk);
            case (which)
                0: seen = irq_take;
                1: seen = hnd_valid;
                default: seen = res_valid;
            endcase
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_req = 0; iret_req = 0; at_boundary = 0; corrupt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_ctx(input logic [BW-1:0] b, input logic [3:0] id);
        {ctx_ip, ctx_regs, ctx_kprev, ctx_knext} = b;
        irq_id = id;
    endtask

    function automatic logic [BW-1:0] mk_blob(input int s);
        return {8'(s * 17 + 3), 4'(s), 4'(~s), 8'(s * 29), 8'(s * 7 + 1), 8'(~(s * 11))};
    endfunction

    // saves context b for handler id, checks R2, R3, R4
    task automatic do_irq(input logic [BW-1:0] b, input logic [3:0] id);
        bit seen;
        int base;
        set_ctx(b, id);
        at_boundary = 1; irq_req = 1;
        base = log_n;
        wait_flag(0, 20, seen);
        chk(seen, "R2", "irq_take", seen, 1);
        chk(flush, "R2", "flush at take", flush, 1);
        irq_req = 0;
        wait_flag(1, 40, seen);
        chk(seen, "R4", "hnd_valid", seen, 1);
        chk(hnd_key == f_mac({36'h0, id}), "R4", "hnd_key", hnd_key, f_mac({36'h0, id}));
        chk(log_op[base] == 2'd2 && log_din[base] == b, "R3", "first op tag on context",
            log_din[base], b);
        chk(log_op[base+1] == 2'd0 && log_din[base+1] == b, "R3", "second op encrypt",
            log_op[base+1], 0);
    endtask

    task automatic do_iret(input logic [BW-1:0] b, input string rq);
        bit seen;
        at_boundary = 1; iret_req = 1;
        @(negedge clk);
        iret_req = 0;
        wait_flag(2, 40, seen);
        chk(seen, rq, "res_valid", seen, 1);
        chk({res_ip, res_regs, res_kdec, res_kchain} == b, rq, "restored context",
            {res_ip, res_regs, res_kdec, res_kchain}, b);
        chk(flush, "R5", "flush at resume", flush, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        bit bad;
        do_reset();
        // R1
        chk(!busy && !halt && !cr_req && !irq_take && !flush && !hnd_valid && !res_valid,
            "R1", "reset outputs", {busy, halt, cr_req, irq_take, flush}, 0);

        // sweep every handler number: boundary gating, save, restore
        for (int s = 0; s < 16; s++) begin
            set_ctx(mk_blob(s), 4'(s));
            irq_req = 1; at_boundary = 0;
            bad = 0;
            repeat (3) begin
                @(negedge clk);
                if (irq_take || busy) bad = 1;
            end
            chk(!bad, "R2", "no take off boundary", bad, 0);
            do_irq(mk_blob(s), 4'(s));
            do_iret(mk_blob(s), "R5");
        end

        // R7 pending during save, then R8 LIFO
        do_irq(mk_blob(20), 4'd3);
        set_ctx(mk_blob(21), 4'd9);
        irq_req = 1;
        @(negedge clk);
        bad = 0;
        while (!irq_take && !hnd_valid) begin
            @(negedge clk);
        end
        // first save already completed in do_irq; exercise a save with a waiting request
        irq_req = 0;
        wait_flag(1, 40, seen);
        do_iret(mk_blob(21), "R8");
        do_iret(mk_blob(20), "R8");

        set_ctx(mk_blob(30), 4'd5);
        at_boundary = 1; irq_req = 1;
        wait_flag(0, 20, seen);
        set_ctx(mk_blob(31), 4'd6);
        bad = 0;
        while (!hnd_valid) begin
            @(negedge clk);
            if (irq_take) bad = 1;
        end
        chk(!bad, "R7", "no take during save", bad, 0);
        chk(hnd_key == f_mac({36'h0, 4'd5}), "R7", "first handler key", hnd_key, f_mac({36'h0, 4'd5}));
        wait_flag(0, 5, seen);
        chk(seen, "R7", "pending irq taken after save", seen, 1);
        irq_req = 0;
        wait_flag(1, 40, seen);
        chk(hnd_key == f_mac({36'h0, 4'd6}), "R7", "second handler key", hnd_key, f_mac({36'h0, 4'd6}));
        do_iret(mk_blob(31), "R8");

        // R7 pending during restore
        iret_req = 1;
        @(negedge clk);
        iret_req = 0;
        set_ctx(mk_blob(40), 4'd12);
        irq_req = 1;
        bad = 0;
        seen = 0;
        while (!res_valid) begin
            @(negedge clk);
            if (irq_take) bad = 1;
        end
        chk(!bad, "R7", "no take during restore", bad, 0);
        chk({res_ip, res_regs, res_kdec, res_kchain} == mk_blob(30), "R8", "older context",
            {res_ip, res_regs, res_kdec, res_kchain}, mk_blob(30));
        wait_flag(0, 5, seen);
        chk(seen, "R7", "pending irq taken after restore", seen, 1);
        irq_req = 0;
        wait_flag(1, 40, seen);
        do_iret(mk_blob(40), "R5");

        // R11 both requests at once with one record held
        do_irq(mk_blob(50), 4'd1);
        set_ctx(mk_blob(51), 4'd2);
        irq_req = 1; iret_req = 1;
        @(negedge clk);
        chk(irq_take && !res_valid, "R11", "irq wins", irq_take, 1);
        irq_req = 0; iret_req = 0;
        wait_flag(1, 40, seen);
        do_iret(mk_blob(51), "R11");
        do_iret(mk_blob(50), "R11");

        // R9 overflow, then R12 halted behaviour
        do_irq(mk_blob(60), 4'd7);
        do_irq(mk_blob(61), 4'd8);
        set_ctx(mk_blob(62), 4'd10);
        irq_req = 1;
        wait_flag(0, 5, seen);
        chk(!seen, "R9", "no take on overflow", seen, 0);
        chk(halt, "R9", "halt on overflow", halt, 1);
        irq_req = 0; iret_req = 1;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (cr_req || res_valid || !halt || busy) bad = 1;
        end
        chk(!bad, "R12", "halt holds, no request", bad, 0);
        do_reset();

        // R10 underflow
        iret_req = 1; at_boundary = 1;
        @(negedge clk);
        iret_req = 0;
        @(negedge clk);
        chk(halt && !res_valid, "R10", "halt on empty return", halt, 1);
        do_reset();

        // R6 tampered record
        do_irq(mk_blob(70), 4'd4);
        corrupt = 1;
        iret_req = 1;
        @(negedge clk);
        iret_req = 0;
        wait_flag(2, 30, seen);
        chk(!seen, "R6", "no resume on bad tag", seen, 0);
        chk(halt, "R6", "halt on bad tag", halt, 1);
        do_reset();
        chk(!halt && !busy, "R1", "reset clears halt", halt, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule